// File: doc/BRIEF.md
# Pending Translation Request Snoop Tracker

This block sits beside a device-side address translation cache and tracks every translation request that has gone out and has not yet been answered. Translation answers and invalidations reach the device on different ordering channels, so an invalidation can arrive before the answer to an earlier request for the same pages. If that answer were then installed, the cache would hold a translation that the host has already withdrawn. The tracker prevents this. It compares each arriving invalidation against all pending requests in one cycle and poisons every request whose page range overlaps. When the answer to a poisoned request arrives, the tracker tells the cache to throw it away.

The tracker keeps one slot per request tag. When a request is issued, the slot records the page range that the request covers. When the answer arrives, the tracker classifies it as keep or drop and frees the slot. One cycle after each invalidation, the tracker raises a done pulse, together with a flag that says whether any pending request overlapped. The invalidation path can send its completion on that pulse, because every stale answer received up to the invalidation cycle has already been marked for discard. A reset or a function-level reset empties the table and suppresses the done pulse of an invalidation that arrives in the same cycle.

All addresses at the ports are 4 KB page numbers, meaning byte address bits 12 and up.

Top module: `xlat_pend_snoop`

## Requirements
- R1: After rst_n low, or in the cycle after flr is high, every slot is free and inv_done is 0. An invalidation that arrives in the same cycle as flr produces no inv_done. A response for a tag that was pending before flr is dropped.
- R2: An issue with page p, length field L (even, in dwords) and cfg_stu = u covers the page range [b, b + (L/2)·2^u), where b is p rounded down to a multiple of 2^u. A request issued in the same cycle as an overlapping invalidation is recorded unpoisoned.
- R3: A response whose tag has an unpoisoned pending entry gives rsp_keep=1 and rsp_drop=0 in that same cycle, and frees the slot.
- R4: A response whose tag has no pending entry gives rsp_drop=1 and rsp_keep=0.
- R5: An invalidation with inv_s=0 covers exactly the page inv_page. With inv_s=1, let k be the lowest bit of inv_page that is 0. The region is then 2^(k+1) pages, aligned to that size. If inv_page is all ones, the region is the whole address space.
- R6: Every pending entry whose range overlaps the invalidation region is poisoned, and its later response gives rsp_drop=1. An entry that does not overlap is left untouched.
- R7: A response in the same cycle as an invalidation that overlaps its entry gives rsp_drop=1.
- R8: Each invalidation accepted without flr gives an inv_done pulse exactly one cycle later. In the same cycle, inv_hit is 1 if and only if any pending entry overlapped the region.
- R9: Re-issuing a tag whose entry is poisoned replaces that entry with a fresh, unpoisoned one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flr | input | 1 | Function-level reset: clears the table |
| cfg_stu | input | 5 | Smallest translation unit exponent (2^cfg_stu pages) |
| req_valid | input | 1 | Translation request issued this cycle |
| req_tag | input | TAG_W | Tag of the issued request |
| req_page | input | ADDR_W-12 | Untranslated page number of the request |
| req_len | input | LEN_W | Request length field in dwords (even) |
| rsp_valid | input | 1 | Translation response arriving this cycle |
| rsp_tag | input | TAG_W | Tag of the arriving response |
| rsp_keep | output | 1 | Response may be installed in the cache |
| rsp_drop | output | 1 | Response must be discarded |
| inv_valid | input | 1 | Invalidation arriving this cycle |
| inv_page | input | ADDR_W-12 | Page number of the invalidation |
| inv_s | input | 1 | Size bit of the invalidation |
| inv_done | output | 1 | Snoop applied: completion may be sent |
| inv_hit | output | 1 | Snoop poisoned at least one pending entry |

## Verification
The bench aims at the invalidation that overtakes an answer, including the case where both arrive in the same cycle. A tracker without the same-cycle bypass would keep that answer and install a stale translation. It tests the size-bit decoding at the edges, namely a run of low one bits and an all-ones page, and the request ranges just inside and just outside their STU-aligned limits. An off-by-one in either range would poison a neighbouring request or miss the overlapping one. It also covers a request issued in the same cycle as an invalidation, tag reuse after poisoning, and a function-level reset that must silence a pending completion. Getting these wrong would show up as false drops, a stuck stale bit, or a completion sent for a flushed invalidation.

// File: rtl/xps_pkg.sv
`timescale 1ns/1ps
package xps_pkg;
   localparam int PAGE_SHIFT = 12;
   localparam int STU_W      = 5;

   typedef enum logic [1:0] {
      SL_FREE  = 2'd0,
      SL_LIVE  = 2'd1,
      SL_STALE = 2'd2
   } slot_st_t;
endpackage

// File: rtl/xps_req_range.sv
`timescale 1ns/1ps
module xps_req_range
   import xps_pkg::*;
#(
   parameter int PN_W  = 52,
   parameter int LEN_W = 10
) (
   input  logic [PN_W-1:0]  pg,
   input  logic [LEN_W-1:0] len,
   input  logic [STU_W-1:0] stu,
   output logic [PN_W:0]    base,
   output logic [PN_W:0]    lim
);
   logic [PN_W-1:0] unit_mask;
   logic [PN_W:0]   pairs;
   logic [PN_W:0]   span;

   // Round the page down to the unit size; span = pairs of dwords * unit
   always_comb begin
      unit_mask = {PN_W{1'b1}} << stu;
      pairs     = (PN_W+1)'(len >> 1);
      span      = pairs << stu;
      base      = {1'b0, pg & unit_mask};
      lim       = base + span;
   end
endmodule

// File: rtl/xps_inv_region.sv
`timescale 1ns/1ps
module xps_inv_region #(
   parameter int PN_W = 52
) (
   input  logic [PN_W-1:0] pg,
   input  logic            s,
   output logic [PN_W:0]   base,
   output logic [PN_W:0]   lim
);
   logic [PN_W-1:0] low_ones;

   // pg ^ (pg+1) marks the trailing ones plus the first zero above them
   always_comb begin
      low_ones = s ? (pg ^ (pg + 1'b1)) : '0;
      base     = {1'b0, pg & ~low_ones};
      lim      = base + {1'b0, low_ones} + 1'b1;
   end
endmodule

// File: rtl/xps_slot.sv
`timescale 1ns/1ps
module xps_slot
   import xps_pkg::*;
#(
   parameter int PN_W = 52
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flr,
   input  logic          set,
   input  logic [PN_W:0] set_base,
   input  logic [PN_W:0] set_lim,
   input  logic          free,
   input  logic          snoop,
   input  logic [PN_W:0] inv_base,
   input  logic [PN_W:0] inv_lim,
   output logic          hit,
   output slot_st_t      state
);
   logic [PN_W:0] base_q;
   logic [PN_W:0] lim_q;

   always_comb begin
      hit = snoop && (state != SL_FREE) &&
            (base_q < inv_lim) && (inv_base < lim_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SL_FREE;
         base_q <= '0;
         lim_q  <= '0;
      end else if (flr) begin
         state <= SL_FREE;
      end else if (set) begin
         state  <= SL_LIVE;
         base_q <= set_base;
         lim_q  <= set_lim;
      end else if (free) begin
         state <= SL_FREE;
      end else if (hit) begin
         state <= SL_STALE;
      end
   end

   // R2: an issue always lands as a fresh, unpoisoned entry
   p_set_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set && !flr) |=> (state == SL_LIVE));

   // R6: poisoning only ever applies to an entry that was pending
   p_poison_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SL_STALE && $past(state) != SL_STALE) |-> ($past(state) == SL_LIVE));
endmodule

// File: rtl/xlat_pend_snoop.sv
`timescale 1ns/1ps
module xlat_pend_snoop
   import xps_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int TAG_W  = 5,
   parameter int LEN_W  = 10
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flr,
   input  logic [STU_W-1:0]           cfg_stu,
   input  logic                       req_valid,
   input  logic [TAG_W-1:0]           req_tag,
   input  logic [ADDR_W-PAGE_SHIFT-1:0] req_page,
   input  logic [LEN_W-1:0]           req_len,
   input  logic                       rsp_valid,
   input  logic [TAG_W-1:0]           rsp_tag,
   output logic                       rsp_keep,
   output logic                       rsp_drop,
   input  logic                       inv_valid,
   input  logic [ADDR_W-PAGE_SHIFT-1:0] inv_page,
   input  logic                       inv_s,
   output logic                       inv_done,
   output logic                       inv_hit
);
   localparam int PN_W  = ADDR_W - PAGE_SHIFT;
   localparam int DEPTH = 1 << TAG_W;

   generate
      if (PN_W < 8 || TAG_W < 1 || TAG_W > 10 || LEN_W < 2) begin : g_bad_cfg
         initial $error("xlat_pend_snoop: unsupported parameter set");
      end
   endgenerate

   logic [PN_W:0]    rq_base, rq_lim;
   logic [PN_W:0]    iv_base, iv_lim;
   logic [DEPTH-1:0] slot_hit;
   slot_st_t         slot_state [DEPTH];

   xps_req_range #(.PN_W(PN_W), .LEN_W(LEN_W)) u_req_range (
      .pg(req_page), .len(req_len), .stu(cfg_stu),
      .base(rq_base), .lim(rq_lim)
   );

   xps_inv_region #(.PN_W(PN_W)) u_inv_region (
      .pg(inv_page), .s(inv_s), .base(iv_base), .lim(iv_lim)
   );

   generate
      for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
         xps_slot #(.PN_W(PN_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .flr      (flr),
            .set      (req_valid && (req_tag == TAG_W'(gi))),
            .set_base (rq_base),
            .set_lim  (rq_lim),
            .free     (rsp_valid && (rsp_tag == TAG_W'(gi))),
            .snoop    (inv_valid),
            .inv_base (iv_base),
            .inv_lim  (iv_lim),
            .hit      (slot_hit[gi]),
            .state    (slot_state[gi])
         );
      end
   endgenerate

   // Same-cycle snoop hit bypasses the stale bit so the answer is dropped now
   always_comb begin
      rsp_keep = rsp_valid && !flr &&
                 (slot_state[rsp_tag] == SL_LIVE) && !slot_hit[rsp_tag];
      rsp_drop = rsp_valid && !rsp_keep;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inv_done <= 1'b0;
         inv_hit  <= 1'b0;
      end else begin
         inv_done <= inv_valid && !flr;
         inv_hit  <= inv_valid && !flr && (|slot_hit);
      end
   end

   // R8: each accepted invalidation is answered on the next cycle
   p_done_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && !flr) |=> inv_done);

   // R8: no completion without an invalidation behind it
   p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      inv_done |-> $past(inv_valid));

   // R1: a function-level reset silences the pending completion
   p_flr_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
      flr |=> !inv_done);

   // R3: a response frees its slot unless the same tag is re-issued
   p_rsp_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !flr && !(req_valid && req_tag == rsp_tag))
      |=> (slot_state[$past(rsp_tag)] == SL_FREE));

   // R4: keep and drop never coexist and only appear with a response
   p_rsp_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_keep, rsp_drop}) && ((rsp_keep || rsp_drop) == rsp_valid));
endmodule

// File: tb/xlat_pend_snoop_bench.sv
`timescale 1ns/1ps
module xlat_pend_snoop_bench;
   localparam int NT = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flr = 1'b0;
   logic [4:0]  cfg_stu = '0;
   logic        req_valid = 1'b0;
   logic [4:0]  req_tag = '0;
   logic [51:0] req_page = '0;
   logic [9:0]  req_len = '0;
   logic        rsp_valid = 1'b0;
   logic [4:0]  rsp_tag = '0;
   logic        rsp_keep, rsp_drop;
   logic        inv_valid = 1'b0;
   logic [51:0] inv_page = '0;
   logic        inv_s = 1'b0;
   logic        inv_done, inv_hit;

   always #4 clk = ~clk;

   xlat_pend_snoop u_xlat_pend_snoop (
      .clk, .rst_n, .flr, .cfg_stu, .req_valid, .req_tag, .req_page, .req_len,
      .rsp_valid, .rsp_tag, .rsp_keep, .rsp_drop,
      .inv_valid, .inv_page, .inv_s, .inv_done, .inv_hit
   );

   int n_chk = 0;
   int n_bad = 0;

   typedef struct { bit drop; string tg; } rsp_exp_t;
   rsp_exp_t rsp_q[$];

   int              m_st [NT];
   longint unsigned m_b  [NT];
   longint unsigned m_l  [NT];
   bit              exp_done = 1'b0;
   bit              exp_hit  = 1'b0;
   string           exp_tg   = "R1";

   task automatic chk(string tg, string what, longint unsigned act, longint unsigned exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tg, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   function automatic void req_rg(longint unsigned pg, int len, int stu,
                                  output longint unsigned b, output longint unsigned l);
      longint unsigned unit = 64'd1 << stu;
      b = pg - (pg % unit);
      l = b + longint'(len / 2) * unit;
   endfunction

   function automatic void inv_rg(longint unsigned pg, bit s,
                                  output longint unsigned b, output longint unsigned l);
      int k;
      longint unsigned sz;
      if (!s) begin
         b = pg; l = pg + 1;
      end else begin
         k = 0;
         while (k < 52 && pg[k]) k++;
         if (k == 52) begin
            b = 0; l = 64'd1 << 52;
         end else begin
            sz = 64'd1 << (k + 1);
            b = pg - (pg % sz);
            l = b + sz;
         end
      end
   endfunction

   // One cycle of stimulus; checks the registered invalidation outputs of the previous cycle
   task automatic cyc(string tg, bit rq, int rt, longint unsigned rp, int rl,
                      bit rs, int st, bit iv, longint unsigned ip, bit is1, bit f);
      bit hit [NT];
      bit any = 1'b0;
      bit keep;
      longint unsigned ib, il, rb, rl2;
      @(negedge clk);
      chk(exp_tg, "inv_done", inv_done, exp_done);
      if (exp_done) chk(exp_tg, "inv_hit", inv_hit, exp_hit);
      req_valid = rq; req_tag = 5'(rt); req_page = 52'(rp); req_len = 10'(rl);
      rsp_valid = rs; rsp_tag = 5'(st);
      inv_valid = iv; inv_page = 52'(ip); inv_s = is1; flr = f;
      inv_rg(ip, is1, ib, il);
      for (int i = 0; i < NT; i++) begin
         hit[i] = iv && (m_st[i] != 0) && (m_b[i] < il) && (ib < m_l[i]);
         if (hit[i]) any = 1'b1;
      end
      if (rs) begin
         keep = !f && (m_st[st] == 1) && !hit[st];
         rsp_q.push_back('{drop: !keep, tg: tg});
      end
      exp_done = iv && !f;
      exp_hit  = exp_done && any;
      exp_tg   = tg;
      req_rg(rp, rl, int'(cfg_stu), rb, rl2);
      for (int i = 0; i < NT; i++) begin
         if (f) m_st[i] = 0;
         else if (rq && rt == i) begin m_st[i] = 1; m_b[i] = rb; m_l[i] = rl2; end
         else if (rs && st == i) m_st[i] = 0;
         else if (hit[i]) m_st[i] = 2;
      end
   endtask

   task automatic issue(string tg, int t, longint unsigned p, int len);
      cyc(tg, 1, t, p, len, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic respond(string tg, int t);
      cyc(tg, 0, 0, 0, 0, 1, t, 0, 0, 0, 0);
   endtask
   task automatic inval(string tg, longint unsigned p, bit s);
      cyc(tg, 0, 0, 0, 0, 0, 0, 1, p, s, 0);
   endtask
   task automatic idle(string tg);
      cyc(tg, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   // Monitor: compares each response classification against the scoreboard
   initial begin
      rsp_exp_t e;
      forever begin
         @(negedge clk);
         #3;
         if (rsp_valid) begin
            if (rsp_q.size() == 0) begin
               n_chk++; n_bad++;
               $display("FAIL R3 unexpected response actual=1 expected=0");
            end else begin
               e = rsp_q.pop_front();
               chk(e.tg, "rsp_drop", rsp_drop, e.drop);
               chk(e.tg, "rsp_keep", rsp_keep, !e.drop);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   localparam longint unsigned P = 64'h10000;

   initial begin
      for (int i = 0; i < NT; i++) begin m_st[i] = 0; m_b[i] = 0; m_l[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1", "inv_done", inv_done, 0);
      chk("R1", "rsp_keep", rsp_keep, 0);
      chk("R1", "rsp_drop", rsp_drop, 0);
      rst_n = 1'b1;
      idle("R1");
      respond("R4", 0);                       // R4 unknown tag after reset
      issue("R3", 1, P, 2); respond("R3", 1); // R3 kept
      respond("R4", 1);                       // R4 freed slot
      issue("R6", 2, P, 2); inval("R8", P, 0); idle("R8");
      respond("R6", 2);                       // R6 poisoned -> drop
      issue("R5", 3, P, 2); inval("R5", P + 1, 0); idle("R5");
      respond("R6", 3);                       // R6 neighbour untouched
      issue("R5", 4, P + 9, 2); issue("R5", 5, P + 16, 2);
      inval("R5", P + 7, 1); idle("R5");      // R5 16-page region
      respond("R5", 4); respond("R5", 5);
      idle("R2"); cfg_stu = 5'd1;
      issue("R2", 6, P + 33, 8); inval("R2", P + 39, 0); idle("R2");
      respond("R2", 6);                       // R2 last page inside
      issue("R2", 6, P + 33, 8); inval("R2", P + 40, 0); idle("R2");
      respond("R2", 6);                       // R2 one past the end
      issue("R2", 7, P + 33, 8); inval("R2", P + 31, 0); idle("R2");
      respond("R2", 7);                       // R2 below aligned base
      cfg_stu = 5'd0;
      issue("R7", 8, P + 100, 2);
      cyc("R7", 0, 0, 0, 0, 1, 8, 1, P + 100, 0, 0); // R7 same-cycle overlap
      idle("R8");
      cyc("R2", 1, 9, P + 200, 2, 0, 0, 1, P + 200, 0, 0); // R2 same-cycle issue
      idle("R2"); respond("R2", 9);
      issue("R1", 10, P, 2);
      cyc("R1", 0, 0, 0, 0, 0, 0, 1, P, 0, 1); // R1 flr with invalidation
      idle("R1"); respond("R1", 10);
      issue("R5", 11, P + 5, 2);
      inval("R5", 64'hF_FFFF_FFFF_FFFF, 1); idle("R5");
      respond("R5", 11);                      // R5 whole space
      issue("R6", 12, P + 300, 2); issue("R6", 13, P + 301, 2);
      issue("R6", 14, P + 400, 2);
      inval("R6", P + 300, 1); idle("R6");
      respond("R6", 12); respond("R6", 13); respond("R6", 14);
      issue("R9", 15, P + 500, 2); inval("R9", P + 500, 0);
      issue("R9", 15, P + 600, 2); idle("R9");
      respond("R9", 15);                      // R9 re-issue clears poison
      idle("R8"); idle("R8");
      @(negedge clk);
      chk("R3", "pending scoreboard", rsp_q.size(), 0);
      finish_run();
   end
endmodule